// File: doc/BRIEF.md
# Byte-Pair Register Bridge

This block lets a narrow byte-wide bus read and write a bank of registers that are twice as wide as the bus, without ever observing or producing a half-updated value. Each wide register appears as two byte addresses: its low half at an even address and its high half at the following odd address. A single holding byte, shared by the whole bank, carries the high half between the two accesses of a pair.

A write pair goes high byte first. The high-byte write only fills the holding byte. The low-byte write then commits the holding byte and the new low byte to the selected register on one clock edge. A read pair goes the other way round. The low-byte read returns the low byte and, on the same edge, copies that register's high byte into the holding byte. The high-byte read that follows returns the holding byte. Core logic sees every register on a flat output vector and can load any register through a per-register update strobe.

Top module: `bpb_bridge`

## Requirements
- R1: After synchronous reset every wide register and the shared holding byte are zero.
- R2: A bus write to an odd in-range address (register k at 2k+1) loads the holding byte with the write data and changes no wide register.
- R3: A bus write to an even in-range address (register k at 2k) loads register k with {holding byte, write data} at that clock edge. The holding byte is shared, so a high-byte write aimed at one register feeds the next low-byte commit to any register.
- R4: A bus read of even address 2k returns the low byte of register k in the same cycle, and at that edge copies the high byte of register k into the holding byte.
- R5: A bus read of an odd in-range address returns the holding byte as it was last loaded, whether or not a low-byte read came before, and leaves it unchanged.
- R6: Asserting bit k of the core update strobe loads register k from word k of the core data input at the next edge.
- R7: When a bus low-byte write and a core update target the same register in the same cycle, the register takes the bus value.
- R8: When a core update and a bus low-byte read hit the same register in the same cycle, the read returns the old low byte and the holding byte captures the old high byte.
- R9: Addresses at or above twice the register count are ignored: writes change neither the registers nor the holding byte, and reads return zero.
- R10: When the write and read strobes are both asserted, the access is a write only: no read data is returned and a read capture into the holding byte does not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Byte write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Byte read data, valid in the strobe cycle |
| core_upd | input | NUM_REGS | Per-register core load strobe |
| core_data | input | NUM_REGS*2*DATA_W | Core load values, word k for register k |
| reg_val | output | NUM_REGS*2*DATA_W | Current value of every wide register |

## Verification
A bus access and a core update can land on the same register in the same cycle. The bench provokes this twice. In the first case a low-byte write and an update strobe hit one register together, and the register must afterwards hold the bus pair. In the second case a low-byte read and an update coincide, and both the returned low byte and the following high-byte read must show the pre-update word, while the output vector shows the core value.

// File: rtl/bpb_pkg.sv
package bpb_pkg;

    // Kind of bus access seen in one cycle
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WR_LO = 3'd1,
        OP_WR_HI = 3'd2,
        OP_RD_LO = 3'd3,
        OP_RD_HI = 3'd4
    } bpb_op_e;

    // Write strobe takes precedence over read strobe; out-of-range is dropped.
    function automatic bpb_op_e bpb_classify(input logic wr, input logic rd,
                                             input logic in_range, input logic hi);
        bpb_op_e op;
        op = OP_NONE;
        if (in_range) begin
            if (wr)      op = hi ? OP_WR_HI : OP_WR_LO;
            else if (rd) op = hi ? OP_RD_HI : OP_RD_LO;
        end
        return op;
    endfunction

endpackage

// File: rtl/bpb_decode.sv
module bpb_decode
    import bpb_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 8,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bpb_op_e           op,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] pair;
    logic              in_range;

    always_comb begin
        pair     = {1'b0, addr[ADDR_W-1:1]};
        in_range = pair < ADDR_W'(NUM_REGS);
        idx      = pair[IDX_W-1:0];
        op       = bpb_classify(wr, rd, in_range, addr[0]);
    end
endmodule

// File: rtl/bpb_temp.sv
module bpb_temp
    import bpb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bpb_op_e           op,
    input  logic [DATA_W-1:0] bus_byte,
    input  logic [DATA_W-1:0] reg_hi,
    output logic [DATA_W-1:0] temp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
        end else begin
            case (op)
                OP_WR_HI: temp_q <= bus_byte;
                OP_RD_LO: temp_q <= reg_hi;
                default:  temp_q <= temp_q;
            endcase
        end
    end
endmodule

// File: rtl/bpb_regfile.sv
module bpb_regfile
    import bpb_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    localparam int WORD_W  = 2 * DATA_W,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  bpb_op_e                    op,
    input  logic [IDX_W-1:0]           idx,
    input  logic [DATA_W-1:0]          bus_byte,
    input  logic [DATA_W-1:0]          temp_q,
    input  logic [NUM_REGS-1:0]        core_upd,
    input  logic [NUM_REGS*WORD_W-1:0] core_data,
    output logic [NUM_REGS*WORD_W-1:0] regs
);
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        logic bus_hit;
        assign bus_hit = (op == OP_WR_LO) && (idx == IDX_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[k*WORD_W +: WORD_W] <= '0;
            end else if (bus_hit) begin
                regs[k*WORD_W +: WORD_W] <= {temp_q, bus_byte};
            end else if (core_upd[k]) begin
                regs[k*WORD_W +: WORD_W] <= core_data[k*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/bpb_bridge.sv
module bpb_bridge
    import bpb_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NUM_REGS-1:0]          core_upd,
    input  logic [NUM_REGS*2*DATA_W-1:0] core_data,
    output logic [NUM_REGS*2*DATA_W-1:0] reg_val
);
    localparam int WORD_W = 2 * DATA_W;
    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    bpb_op_e           op;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] temp_q;
    logic [WORD_W-1:0] sel_word;

    bpb_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .op   (op),
        .idx  (idx)
    );

    assign sel_word = reg_val[idx*WORD_W +: WORD_W];

    bpb_temp #(.DATA_W(DATA_W)) u_temp (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .bus_byte (bus_wdata),
        .reg_hi   (sel_word[WORD_W-1:DATA_W]),
        .temp_q   (temp_q)
    );

    bpb_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .idx       (idx),
        .bus_byte  (bus_wdata),
        .temp_q    (temp_q),
        .core_upd  (core_upd),
        .core_data (core_data),
        .regs      (reg_val)
    );

    always_comb begin
        case (op)
            OP_RD_LO: bus_rdata = sel_word[DATA_W-1:0];
            OP_RD_HI: bus_rdata = temp_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bpb_bridge_chk.sv
module bpb_bridge_chk #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [NUM_REGS-1:0]          core_upd,
    input logic [NUM_REGS*2*DATA_W-1:0] reg_val,
    input logic [DATA_W-1:0]            temp_q
);
    localparam int WORD_W = 2 * DATA_W;
    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [ADDR_W-1:0] half_addr;
    logic              in_rng;
    logic [IDX_W-1:0]  widx;
    logic [IDX_W-1:0]  last_idx;
    logic [WORD_W-1:0] last_word;
    logic [DATA_W-1:0] cur_hi;

    assign half_addr = bus_addr >> 1;
    assign in_rng    = half_addr < ADDR_W'(NUM_REGS);
    assign widx      = half_addr[IDX_W-1:0];
    assign cur_hi    = reg_val[widx*WORD_W + DATA_W +: DATA_W];
    assign last_word = reg_val[last_idx*WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
        if (rst) last_idx <= '0;
        else     last_idx <= widx;
    end

    p_wrhi_temp_only_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[0] && in_rng && core_upd == '0)
        |=> (reg_val == $past(reg_val)) && (temp_q == $past(bus_wdata)));

    // Covers R7 as well: the bus pair must land even with a core strobe present.
    p_wrlo_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[0] && in_rng)
        |=> (last_word == {$past(temp_q), $past(bus_wdata)}) && $stable(temp_q));

    p_rdlo_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && !bus_addr[0] && in_rng)
        |=> temp_q == $past(cur_hi));

    p_rdhi_temp_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr[0] && in_rng)
        |-> bus_rdata == temp_q);

    p_rdhi_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr[0] && in_rng) |=> $stable(temp_q));

    p_oor_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && !in_rng && core_upd == '0)
        |=> $stable(reg_val) && $stable(temp_q));

    p_oor_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !in_rng) |-> bus_rdata == '0);

    p_both_write_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr) |-> bus_rdata == '0);
endmodule

bind bpb_bridge bpb_bridge_chk #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .core_upd  (core_upd),
    .reg_val   (reg_val),
    .temp_q    (temp_q)
);

// File: tb/tb_bpb_bridge.sv
`timescale 1ns/1ps
module tb_bpb_bridge;
    localparam int NR = 4;
    localparam int DW = 8;
    localparam int AW = 8;
    localparam int WW = 2 * DW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [AW-1:0]    bus_addr = '0;
    logic [DW-1:0]    bus_wdata = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [DW-1:0]    bus_rdata;
    logic [NR-1:0]    core_upd = '0;
    logic [NR*WW-1:0] core_data = '0;
    logic [NR*WW-1:0] reg_val;

    bpb_bridge #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .core_upd(core_upd), .core_data(core_data), .reg_val(reg_val)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [WW-1:0] m_reg [NR];
    logic [DW-1:0] m_temp;

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            finish_run();
        end
    end

    // Monitor: pops expected read bytes and compares them with the bus.
    always @(negedge clk) begin
        if (bus_rd && !bus_wr && !rst) begin
            checks = checks + 1;
            if (exp_q.size() == 0) begin
                fails = fails + 1;
                $display("FAIL read with empty scoreboard: actual=%h expected=none", bus_rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    fails = fails + 1;
                    $display("FAIL %s read addr %0d: actual=%h expected=%h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        if ((a >> 1) >= NR) return '0;
        if (a[0]) return m_temp;
        return m_reg[a >> 1][DW-1:0];
    endfunction

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        if ((a >> 1) < NR) begin
            if (a[0]) m_temp = d;
            else      m_reg[a >> 1] = {m_temp, d};
        end
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input string t);
        exp_q.push_back(model_read(a));
        tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        if ((a >> 1) < NR && !a[0]) m_temp = m_reg[a >> 1][WW-1:DW];
    endtask

    task automatic check_regs(input string t);
        for (int k = 0; k < NR; k++) begin
            checks = checks + 1;
            if (reg_val[k*WW +: WW] !== m_reg[k]) begin
                fails = fails + 1;
                $display("FAIL %s reg %0d: actual=%h expected=%h", t, k, reg_val[k*WW +: WW], m_reg[k]);
            end
        end
    endtask

    initial begin
        for (int k = 0; k < NR; k++) m_reg[k] = '0;
        m_temp = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check_regs("R1");
        bus_read(8'd1, "R1");

        // R2: high write touches only the holding byte
        bus_write(8'd5, 8'hA7);
        check_regs("R2");
        bus_read(8'd5, "R2");

        // R3: low write commits the pair
        bus_write(8'd4, 8'h3C);
        check_regs("R3");
        // R3: shared holding byte across registers
        bus_write(8'd3, 8'h91);
        bus_write(8'd0, 8'h22);
        check_regs("R3");

        // R4/R5: read pair
        bus_read(8'd4, "R4");
        bus_read(8'd5, "R4");
        bus_read(8'd0, "R4");
        bus_read(8'd1, "R5");
        bus_read(8'd1, "R5");
        // R5: high read without low read gives last holding value
        bus_write(8'd7, 8'h5E);
        bus_read(8'd3, "R5");

        // R6: core update alone
        core_data[3*WW +: WW] = 16'hBEEF;
        core_upd = 4'b1000;
        @(posedge clk); #1;
        core_upd = '0;
        m_reg[3] = 16'hBEEF;
        check_regs("R6");
        bus_read(8'd6, "R6");
        bus_read(8'd7, "R6");

        // R7: bus low write and core update on register 1 together
        bus_write(8'd3, 8'h44);
        core_data[1*WW +: WW] = 16'hFFFF;
        core_upd = 4'b0010;
        bus_write(8'd2, 8'h66);
        core_upd = '0;
        check_regs("R7");

        // R8: low read and core update on register 0 together
        core_data[0*WW +: WW] = 16'h1357;
        core_upd = 4'b0001;
        bus_read(8'd0, "R8");
        core_upd = '0;
        m_reg[0] = 16'h1357;
        check_regs("R8");
        bus_read(8'd1, "R8");

        // R9: out-of-range addresses
        bus_write(8'd8, 8'hEE);
        bus_write(8'd9, 8'hDD);
        check_regs("R9");
        bus_read(8'd9, "R9");
        bus_read(8'd1, "R9");

        // R10: both strobes: write only, no capture
        bus_write(8'd3, 8'h0F);
        bus_addr = 8'd4; bus_wdata = 8'h81; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        checks = checks + 1;
        if (bus_rdata !== 8'h00) begin
            fails = fails + 1;
            $display("FAIL R10 rdata: actual=%h expected=00", bus_rdata);
        end
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        m_reg[2] = {m_temp, 8'h81};
        check_regs("R10");
        bus_read(8'd5, "R10");

        repeat (2) @(posedge clk);
        checks = checks + 1;
        if (exp_q.size() != 0) begin
            fails = fails + 1;
            $display("FAIL scoreboard residue: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule